// File: doc/BRIEF.md
# Latched 64-bit Match Timer

A system timer built around a 64-bit up-counter that never stops. A programmable prescaler sets how fast the counter advances: one step for every 2*(DIV+1) cycles of the block clock. Software sees the block through a plain 32-bit register port. It can load either half of the counter, program six 32-bit compare values, enable interrupts per channel and clear event flags by writing ones to them.

Reading a 64-bit count as two 32-bit words can tear: the low word may wrap between the two reads. A capture command avoids this. It copies the whole count into two snapshot registers in one clock, and the snapshot keeps that value until the next capture. Compare channel 5 doubles as a watchdog. When the watchdog is armed, an event on that channel raises a reset request for the rest of the chip.

Top module: `tick64_timer`

## Requirements
- R1: After reset every register reads zero and all outputs are low. A read from a word offset with no register behind it (byte offset 0x3C, or word index 15) returns zero, and so does a read of the capture command word.
- R2: The divider register (byte offset 0x2C, low DIV_W bits) sets the step period to 2*(DIV+1) clocks. After the counter is loaded, the count a capture sees after W further idle clocks is floor(W / (2*(DIV+1))) above the loaded value.
- R3: Writing a word with bit 0 set to byte offset 0x30 copies the full 64-bit count into the snapshot registers (low word at 0x34, high word at 0x38) at that clock edge. The snapshot then stays unchanged until the next capture, whatever the counter does.
- R4: Software can write the counter's low word (byte offset 0x00) and high word (0x04). The new value applies at the next edge, and any partly elapsed step period is thrown away. Without a write, the count changes by at most one per clock.
- R5: When the low word wraps from 0xFFFFFFFF to 0, the high word increments.
- R6: Compare channel n has its value at byte offset 0x08+4n. The step that brings the counter's low word to that value sets bit n of the status register (0x20). The flag then stays set until software writes a 1 to that bit.
- R7: If a compare event and a write-one-to-clear of the same status bit fall on the same clock, the flag stays set.
- R8: One cycle after status bit n and enable bit n (register 0x24) are both set, output irq_chan[n] is high. irq_any is the OR of all channels with the same latency. A cleared enable bit masks the interrupt, while the flag is still recorded and the counter keeps running.
- R9: When bit 0 of the watchdog arm register (0x28) is set and status bit 5 is set, wdog_rst_req goes high one cycle later. The interrupt enable has no effect on it. With the watchdog disarmed, the request stays low.
- R10: bus_rdata updates one cycle after a clock with bus_rd high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_chan | output | N_MATCH | Per-channel interrupt lines |
| irq_any | output | 1 | OR of all enabled, flagged channels |
| wdog_rst_req | output | 1 | Watchdog reset request |

## Verification
The hardest case to create from the ports is a compare event that lands on exactly the clock where software writes one to clear the same flag. Reaching it depends on the prescaler phase and on when the counter was loaded. The bench sets the divider to zero and loads the counter a known distance below the compare value, which puts the event at a computable edge. It then times the clearing write to that exact edge. The same cycle accounting places the capture commands and the interrupt and watchdog samples on precise edges. Random divider values, wait lengths and compare distances are mixed in with these directed cases.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef logic [31:0] word_t;
  // register word indices (byte offset / 4)
  localparam int unsigned W_CNT_LO  = 0;
  localparam int unsigned W_CNT_HI  = 1;
  localparam int unsigned W_MATCH0  = 2;
  localparam int unsigned W_STAT    = 8;
  localparam int unsigned W_IEN     = 9;
  localparam int unsigned W_WDEN    = 10;
  localparam int unsigned W_DIV     = 11;
  localparam int unsigned W_LATCH   = 12;
  localparam int unsigned W_SNAP_LO = 13;
  localparam int unsigned W_SNAP_HI = 14;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  localparam int PH_W = DIV_W + 1;
  logic [PH_W-1:0] ph_q;
  logic            at_end;

  // period is 2*(div+1): phase runs 0 .. 2*div+1
  assign at_end = (ph_q == {div, 1'b1});
  assign tick   = at_end && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart || at_end) ph_q <= '0;
    else                          ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/tt_counter64.sv
module tt_counter64 #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] cnt_lo,
  output logic [HALF_W-1:0] cnt_hi
);
  logic lo_wrap;
  assign lo_wrap = &cnt_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_lo <= wdata;
      if (wr_hi) cnt_hi <= wdata;
    end else if (tick) begin
      cnt_lo <= cnt_lo + 1'b1;
      if (lo_wrap) cnt_hi <= cnt_hi + 1'b1;
    end
  end
endmodule

// File: rtl/tt_match_bank.sv
module tt_match_bank #(
  parameter int N     = 6,
  parameter int CMP_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic [CMP_W-1:0]        cnt_lo,
  input  logic [N-1:0][CMP_W-1:0] cmp_val,
  input  logic [N-1:0]            clr_mask,
  output logic [N-1:0]            status
);
  logic [CMP_W-1:0] lo_next;
  logic [N-1:0]     hit;

  assign lo_next = cnt_lo + 1'b1;

  for (genvar n = 0; n < N; n++) begin : g_cmp
    assign hit[n] = tick && (lo_next == cmp_val[n]);
  end

  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_mask) | hit;
  end
endmodule

// File: rtl/tick64_timer.sv
module tick64_timer #(
  parameter int ADDR_W   = 6,
  parameter int N_MATCH  = 6,
  parameter int WDOG_CH  = 5,
  parameter int DIV_W    = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_rd,
  output logic [31:0]        bus_rdata,
  output logic [N_MATCH-1:0] irq_chan,
  output logic               irq_any,
  output logic               wdog_rst_req
);
  import tt_pkg::*;

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]          widx;
  int unsigned               widx_u;
  logic [N_MATCH-1:0][31:0]  cmp_q;
  logic [N_MATCH-1:0]        ien_q;
  logic                      wden_q;
  logic [DIV_W-1:0]          div_q;
  logic [31:0]               snap_lo_q, snap_hi_q;
  logic [31:0]               cnt_lo, cnt_hi;
  logic [N_MATCH-1:0]        stat_q;
  logic [N_MATCH-1:0]        clr_mask;
  logic                      wr_lo, wr_hi, wr_div, wr_latch, tick;
  word_t                     rd_mux;

  assign widx     = bus_addr[ADDR_W-1:2];
  assign widx_u   = int'(widx);
  assign wr_lo    = bus_wr && (widx_u == W_CNT_LO);
  assign wr_hi    = bus_wr && (widx_u == W_CNT_HI);
  assign wr_div   = bus_wr && (widx_u == W_DIV);
  assign wr_latch = bus_wr && (widx_u == W_LATCH) && bus_wdata[0];
  assign clr_mask = (bus_wr && (widx_u == W_STAT)) ? bus_wdata[N_MATCH-1:0] : '0;

  tt_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst(rst), .div(div_q),
    .restart(wr_lo || wr_hi || wr_div), .tick(tick)
  );

  tt_counter64 #(.HALF_W(32)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(bus_wdata), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
  );

  tt_match_bank #(.N(N_MATCH), .CMP_W(32)) u_match (
    .clk(clk), .rst(rst), .tick(tick), .cnt_lo(cnt_lo),
    .cmp_val(cmp_q), .clr_mask(clr_mask), .status(stat_q)
  );

  for (genvar n = 0; n < N_MATCH; n++) begin : g_cmp_reg
    always_ff @(posedge clk) begin
      if (rst)                                          cmp_q[n] <= '0;
      else if (bus_wr && (widx_u == W_MATCH0 + n))      cmp_q[n] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q     <= '0;
      wden_q    <= 1'b0;
      div_q     <= '0;
      snap_lo_q <= '0;
      snap_hi_q <= '0;
    end else begin
      if (bus_wr && (widx_u == W_IEN))  ien_q  <= bus_wdata[N_MATCH-1:0];
      if (bus_wr && (widx_u == W_WDEN)) wden_q <= bus_wdata[0];
      if (wr_div)                       div_q  <= bus_wdata[DIV_W-1:0];
      if (wr_latch) begin
        snap_lo_q <= cnt_lo;
        snap_hi_q <= cnt_hi;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (widx_u)
      W_CNT_LO:  rd_mux = cnt_lo;
      W_CNT_HI:  rd_mux = cnt_hi;
      W_STAT:    rd_mux = 32'(stat_q);
      W_IEN:     rd_mux = 32'(ien_q);
      W_WDEN:    rd_mux = 32'(wden_q);
      W_DIV:     rd_mux = 32'(div_q);
      W_SNAP_LO: rd_mux = snap_lo_q;
      W_SNAP_HI: rd_mux = snap_hi_q;
      default: begin
        for (int n = 0; n < N_MATCH; n++)
          if (widx_u == W_MATCH0 + n) rd_mux = cmp_q[n];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata    <= '0;
      irq_chan     <= '0;
      irq_any      <= 1'b0;
      wdog_rst_req <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq_chan     <= stat_q & ien_q;
      irq_any      <= |(stat_q & ien_q);
      wdog_rst_req <= stat_q[WDOG_CH] && wden_q;
    end
  end
endmodule

// File: rtl/tick64_timer_checker.sv
module tick64_timer_checker #(
  parameter int ADDR_W  = 6,
  parameter int N_MATCH = 6
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic [31:0]        bus_wdata,
  input logic               bus_rd,
  input logic [31:0]        bus_rdata,
  input logic [N_MATCH-1:0] irq_chan,
  input logic               wdog_rst_req,
  input logic [N_MATCH-1:0] stat,
  input logic [N_MATCH-1:0] ien,
  input logic               wden,
  input logic [63:0]        count,
  input logic [63:0]        snap
);
  logic [ADDR_W-3:0]  idx;
  logic               cmd_latch, cmd_cnt;
  logic [N_MATCH-1:0] keep;

  assign idx       = bus_addr[ADDR_W-1:2];
  assign cmd_latch = bus_wr && (int'(idx) == 12) && bus_wdata[0];
  assign cmd_cnt   = bus_wr && (int'(idx) <= 1);
  assign keep      = (bus_wr && int'(idx) == 8) ? (stat & ~bus_wdata[N_MATCH-1:0]) : stat;

  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && int'(idx) == 15) |=> (bus_rdata == 32'd0));
  p_snap_take_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_latch |=> (snap == $past(count)));
  p_snap_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !cmd_latch |=> $stable(snap));
  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    !cmd_cnt |=> (count == $past(count) || count == $past(count) + 64'd1));
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat & $past(keep)) == $past(keep)));
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_chan & ~$past(ien)) == '0));
  p_wdog_off_r9: assert property (@(posedge clk) disable iff (rst)
    !wden |=> !wdog_rst_req);
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind tick64_timer tick64_timer_checker #(.ADDR_W(ADDR_W), .N_MATCH(N_MATCH)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .irq_chan(irq_chan), .wdog_rst_req(wdog_rst_req),
  .stat(stat_q), .ien(ien_q), .wden(wden_q),
  .count({cnt_hi, cnt_lo}), .snap({snap_hi_q, snap_lo_q})
);

// File: tb/tick64_timer_bench.sv
module tick64_timer_bench;
  localparam logic [5:0] A_LO = 6'h00, A_HI = 6'h04, A_M0 = 6'h08, A_STAT = 6'h20,
                         A_IEN = 6'h24, A_WDEN = 6'h28, A_DIV = 6'h2C, A_LATCH = 6'h30,
                         A_SLO = 6'h34, A_SHI = 6'h38, A_NONE = 6'h3C;

  logic        clk = 1'b0, rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [5:0]  irq_chan;
  logic        irq_any, wdog_rst_req;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  tick64_timer u_tick64_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_chan(irq_chan), .irq_any(irq_any),
    .wdog_rst_req(wdog_rst_req)
  );

  // every task starts and ends at a falling edge; each consumes one rising edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] steps(input int w, input int dv);
    return 32'(w / (2 * (dv + 1)));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL timeout actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, s;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_LO, v);   chk(v == 0, "R1 counter reset", v, 0);
    chk(irq_chan == 0 && !irq_any && !wdog_rst_req, "R1 outputs reset", {irq_any, irq_chan}, 0);
    rd(A_STAT, v); chk(v == 0, "R1 status reset", v, 0);
    rd(A_SHI, v);  chk(v == 0, "R1 snapshot reset", v, 0);
    rd(A_NONE, v); chk(v == 0, "R1 unmapped read", v, 0);

    // R2 directed divider
    wr(A_DIV, 32'd2); wr(A_HI, 0); wr(A_LO, 0); idle(13); wr(A_LATCH, 1);
    rd(A_SLO, v); chk(v == steps(13, 2), "R2 div=2 count", v, steps(13, 2));
    rd(A_LATCH, v); chk(v == 0, "R1 latch word reads zero", v, 0);

    // R4 write discards partial step
    wr(A_DIV, 32'd3); wr(A_LO, 0); idle(5); wr(A_LO, 32'd100); idle(7); wr(A_LATCH, 1);
    rd(A_SLO, v); chk(v == 32'd100, "R4 load discards phase", v, 100);

    // R5 carry, R3 hold
    wr(A_DIV, 0); wr(A_HI, 32'd5); wr(A_LO, 32'hFFFF_FFFF); idle(4); wr(A_LATCH, 1);
    rd(A_SHI, v); chk(v == 32'd6, "R5 carry into high", v, 6);
    rd(A_SLO, v); chk(v == 32'd1, "R5 low after wrap", v, 1);
    idle(20);
    rd(A_SLO, v); chk(v == 32'd1, "R3 snapshot held", v, 1);
    rd(A_LO, s);  chk(s > 32'd5, "R3 live counter moved on", s, 6);

    // R2 random divider and wait
    for (int i = 0; i < 16; i++) begin
      int dv, w;
      dv = int'($urandom % 6); w = int'($urandom % 60);
      wr(A_DIV, 32'(dv)); wr(A_HI, 0); wr(A_LO, 0); idle(w); wr(A_LATCH, 1);
      rd(A_SLO, v); chk(v == steps(w, dv), "R2 random period", v, steps(w, dv));
    end

    // R6/R8 random compare events, exact interrupt cycle
    wr(A_DIV, 0); wr(A_IEN, 32'h3F); wr(A_WDEN, 0);
    for (int i = 0; i < 12; i++) begin
      int n, d;
      n = int'($urandom % 6); d = 1 + int'($urandom % 20); s = $urandom;
      wr(A_M0 + 6'(4 * n), s + 32'(d)); wr(A_STAT, 32'h3F); wr(A_LO, s);
      idle(2 * d);
      chk(irq_chan[n] == 1'b0, "R8 irq not early", irq_chan[n], 0);
      idle(1);
      chk(irq_chan[n] == 1'b1 && irq_any, "R6 R8 irq on match", {irq_any, irq_chan[n]}, 3);
      wr(A_STAT, 32'h3F);
    end

    // R7 set wins over clear in same cycle
    wr(A_M0 + 6'd4, 32'h1000_0004); wr(A_STAT, 32'h3F); wr(A_LO, 32'h1000_0000);
    idle(7); wr(A_STAT, 32'h2);
    rd(A_STAT, v); chk(v[1] == 1'b1, "R7 set beats clear", v[1], 1);
    wr(A_STAT, 32'h2);
    rd(A_STAT, v); chk(v[1] == 1'b0, "R6 write one clears", v[1], 0);

    // R8 masked channel still flags, counter runs
    wr(A_IEN, 32'h3B); wr(A_M0 + 6'd8, 32'h2000_0003); wr(A_STAT, 32'h3F); wr(A_LO, 32'h2000_0000);
    idle(10);
    chk(irq_chan[2] == 1'b0, "R8 masked irq low", irq_chan[2], 0);
    rd(A_STAT, v); chk(v[2] == 1'b1, "R8 masked flag set", v[2], 1);
    rd(A_LO, v); chk(v > 32'h2000_0004, "R8 counter runs when masked", v, 32'h2000_0005);
    wr(A_STAT, 32'h3F);

    // R9 watchdog armed, interrupts masked
    wr(A_IEN, 0); wr(A_WDEN, 1); wr(A_M0 + 6'd20, 32'h3000_0002); wr(A_STAT, 32'h3F);
    wr(A_LO, 32'h3000_0000);
    idle(4); chk(wdog_rst_req == 1'b0, "R9 request not early", wdog_rst_req, 0);
    idle(1); chk(wdog_rst_req == 1'b1, "R9 request on match", wdog_rst_req, 1);
    chk(irq_chan[5] == 1'b0, "R9 irq masked", irq_chan[5], 0);
    wr(A_WDEN, 0); idle(1);
    chk(wdog_rst_req == 1'b0, "R9 disarm drops request", wdog_rst_req, 1'b0);

    // R10 read data holds between reads
    rd(A_M0 + 6'd20, v); chk(v == 32'h3000_0002, "R10 read compare value", v, 32'h3000_0002);
    idle(5); chk(bus_rdata == 32'h3000_0002, "R10 rdata held", bus_rdata, 32'h3000_0002);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule